// File: doc/BRIEF.md
# Two-Wire Serial Memory Target

This block is the bus-side front end of a 2 KiB byte-addressed memory. It watches a two-wire serial bus (a clock line and an open-drain data line) with its own system clock. It finds START and STOP conditions, shifts bytes in and out, and answers on the ninth clock of each byte. The first byte after a START selects one of two targets. One is the memory array, reached through a memory-side request port. The other is a small control space that holds a write-enable latch and a block protection setting.

A master sets a 16-bit word address with two bytes, high byte first. It can then write one byte or a run of bytes; a run stays inside one 64-byte page. It can also read from the current address, read from an address it has just set (a dummy write followed by a repeated START), or read continuously. A continuous read steps through the whole array and wraps.

The memory-side port uses valid/ready. A request (read or write) raises `mem_valid_o` and holds `mem_write_o`, `mem_addr_o` and `mem_wdata_o` unchanged until a cycle in which `mem_ready_i` is high. For a read, `mem_rdata_i` is taken in that same accepting cycle. At most one request is outstanding. The memory may stall for any time shorter than about one bus clock period before the byte is needed on the bus.

Top module: `i2cm_target`

## Requirements
- R1: A START is a falling data line while the clock line is high, and a STOP is a rising data line while the clock line is high. The block drives the data line low only to acknowledge or to send a 0 bit. It releases the line at once on any START or STOP. It changes its drive only while the clock line is low, except for that release.
- R2: Bits [7:4] of the first byte after a START select the target: 1010 selects the memory and 1101 selects the control space. Bit 0 = 1 means read. Any other code gets no acknowledge, and the block ignores the bus until the next START.
- R3: The block acknowledges the select byte, both word-address bytes and every write data byte by holding the data line low during the ninth clock.
- R4: The word address is two bytes, high byte first. Only its low 11 bits are used, so the upper 5 bits of the high byte have no effect.
- R5: Each acknowledged memory data byte is written at the current address. The address then advances only in its low 6 bits, so a run that passes the end of a 64-byte page wraps to the start of that page and overwrites earlier bytes there.
- R6: After a write, a current-address read returns the location after the last byte written, taken inside that page.
- R7: A random read (select byte with write, two address bytes, repeated START, select byte with read) returns the byte at the address just set.
- R8: A sequential read, in which the master acknowledges each byte, returns consecutive bytes across the whole array and wraps from 0x7FF to 0x000. A NACK from the master ends the read.
- R9: Control register 0x00 holds the protection setting in bits [1:0]: 0 protects nothing, 1 protects 0x600-0x7FF, 2 protects 0x400-0x7FF, and 3 protects the whole array. A data byte aimed at a protected address is still acknowledged, but no memory write is issued.
- R10: Writing 0x02 to control register 0x01 sets the write-enable latch, and any other value clears it. Register 0x00 takes a write only while the latch is set. A control write takes effect only at a STOP after the acknowledged byte; a repeated START in its place discards it. Reads return the protection setting in bits [1:0] of 0x00 and the latch in bit 1 of 0x01.
- R11: A START or STOP in the middle of a byte abandons that byte: nothing is written and the block returns to idle or address decode.
- R12: A memory request holds valid, direction, address and data stable until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| mem_valid_o | output | 1 | Memory request valid |
| mem_ready_i | input | 1 | Memory accepts the request this cycle |
| mem_write_o | output | 1 | 1 = write request, 0 = read request |
| mem_addr_o | output | 11 | Memory byte address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid in the accepting cycle |

## Verification
A wrong bit count or phase shows at the data line within one byte. The acknowledge lands on the wrong clock, or a read byte comes out shifted. A wrong address pointer does not show right away. It appears only at the next data byte, as data at the wrong location; page wrap and array wrap are invisible until the run crosses a boundary. So the reads aim at those crossings. Control-space faults, such as a commit on a repeated START or a protection write accepted without the latch, stay hidden until a later readback or a dropped write shows them. For that reason each control write is followed by a read of the register.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_AHI,
    PH_ALO,
    PH_WR,
    PH_RD
  } phase_t;

  localparam logic [3:0] CODE_MEM = 4'b1010;
  localparam logic [3:0] CODE_CTL = 4'b1101;

  localparam logic [7:0] CREG_PROT = 8'h00;
  localparam logic [7:0] CREG_WEN  = 8'h01;
  localparam logic [7:0] WEN_KEY   = 8'h02;

  // protection select against the two top address bits
  function automatic logic is_protected(input logic [1:0] sel, input logic [1:0] top2);
    case (sel)
      2'd0:    is_protected = 1'b0;
      2'd1:    is_protected = (top2 == 2'b11);
      2'd2:    is_protected = top2[1];
      default: is_protected = 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/i2cm_line_sync.sv
module i2cm_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_q  <= scl_sh[STAGES-1];
      sda_q  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s     = scl_sh[STAGES-1];
  assign sda_s     = sda_sh[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2cm_ctl_regs.sv
module i2cm_ctl_regs
  import i2cm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stage_valid,
  input  logic [7:0] stage_addr,
  input  logic [7:0] stage_data,
  input  logic       commit,
  input  logic       discard,
  input  logic [7:0] rd_addr,
  output logic [7:0] rd_data,
  output logic [1:0] prot,
  output logic       wel
);
  logic       pend_v;
  logic [7:0] pend_a, pend_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v <= 1'b0;
      pend_a <= '0;
      pend_d <= '0;
      prot   <= 2'd0;
      wel    <= 1'b0;
    end else if (discard) begin
      pend_v <= 1'b0;
    end else if (commit) begin
      pend_v <= 1'b0;
      if (pend_v) begin
        if (pend_a == CREG_WEN) wel <= (pend_d == WEN_KEY);
        else if (pend_a == CREG_PROT && wel) prot <= pend_d[1:0];
      end
    end else if (stage_valid) begin
      pend_v <= 1'b1;
      pend_a <= stage_addr;
      pend_d <= stage_data;
    end
  end

  always_comb begin
    case (rd_addr)
      CREG_PROT: rd_data = {6'd0, prot};
      CREG_WEN:  rd_data = {6'd0, wel, 1'b0};
      default:   rd_data = 8'h00;
    endcase
  end

  // R10: the latch only rises on a STOP commit
  a_r10_wel_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(commit));

  // R10: protection changes only while the latch was set
  a_r10_prot_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prot) |-> ($past(wel) && $past(commit)));

endmodule

// File: rtl/i2cm_target.sv
module i2cm_target
  import i2cm_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int PAGE_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic              mem_write_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i
);
  localparam int HI_W = ADDR_W - 8;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2cm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  phase_t            ph, nxt;
  logic [3:0]        bitcnt;
  logic              in_ack;
  logic [7:0]        sh, rbyte;
  logic [HI_W-1:0]   ahi;
  logic              is_ctl;
  logic [ADDR_W-1:0] addr;
  logic              mreq_v, mreq_w;
  logic [ADDR_W-1:0] mreq_a;
  logic [7:0]        mreq_d;
  logic              sda_oe;
  logic              cst_v;
  logic [7:0]        cst_a, cst_d;
  logic [1:0]        prot;
  logic              wel;
  logic [7:0]        ctl_rd;

  i2cm_ctl_regs u_ctl (
    .clk(clk), .rst_n(rst_n),
    .stage_valid(cst_v), .stage_addr(cst_a), .stage_data(cst_d),
    .commit(stop_det), .discard(start_det),
    .rd_addr(addr[7:0]), .rd_data(ctl_rd), .prot(prot), .wel(wel)
  );

  logic [PAGE_W-1:0] pg_lo;
  logic [ADDR_W-1:0] addr_pg, addr_nx;
  logic              dev_hit, dev_ctl, wr_blocked;

  assign pg_lo      = addr[PAGE_W-1:0] + PAGE_W'(1);
  assign addr_pg    = {addr[ADDR_W-1:PAGE_W], pg_lo};
  assign addr_nx    = addr + ADDR_W'(1);
  assign dev_ctl    = (sh[7:4] == CODE_CTL);
  assign dev_hit    = (sh[7:4] == CODE_MEM) || dev_ctl;
  assign wr_blocked = is_protected(prot, addr[ADDR_W-1 -: 2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE;  nxt <= PH_IDLE;
      bitcnt <= '0;   in_ack <= 1'b0;
      sh <= '0;       ahi <= '0;     rbyte <= '0;
      is_ctl <= 1'b0; addr <= '0;
      mreq_v <= 1'b0; mreq_w <= 1'b0; mreq_a <= '0; mreq_d <= '0;
      sda_oe <= 1'b0;
      cst_v <= 1'b0;  cst_a <= '0;   cst_d <= '0;
    end else begin
      cst_v <= 1'b0;
      if (mreq_v && mem_ready_i) begin
        mreq_v <= 1'b0;
        if (!mreq_w) rbyte <= mem_rdata_i;
      end
      if (start_det) begin
        ph <= PH_DEV; bitcnt <= '0; in_ack <= 1'b0; sda_oe <= 1'b0;
      end else if (stop_det) begin
        ph <= PH_IDLE; bitcnt <= '0; in_ack <= 1'b0; sda_oe <= 1'b0;
      end else if (ph != PH_IDLE) begin
        if (scl_rise) begin
          if (!in_ack) begin
            if (bitcnt != 4'd8) begin
              sh     <= {sh[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end
          end else if (ph == PH_RD) begin
            if (sda_s) begin
              ph <= PH_IDLE;                  // master NACK ends the read
            end else begin
              if (is_ctl) rbyte <= ctl_rd;
              else begin mreq_v <= 1'b1; mreq_w <= 1'b0; mreq_a <= addr; end
              addr <= addr_nx;
            end
          end
        end else if (scl_fall) begin
          if (in_ack) begin
            in_ack <= 1'b0;
            bitcnt <= '0;
            ph     <= nxt;
            if (nxt == PH_RD) begin
              sh     <= rbyte;
              sda_oe <= ~rbyte[7];
            end else begin
              sda_oe <= 1'b0;
            end
          end else if (bitcnt == 4'd8) begin
            in_ack <= 1'b1;
            case (ph)
              PH_DEV: begin
                if (dev_hit) begin
                  sda_oe <= 1'b1;
                  is_ctl <= dev_ctl;
                  nxt    <= sh[0] ? PH_RD : PH_AHI;
                  if (sh[0]) begin
                    if (dev_ctl) rbyte <= ctl_rd;
                    else begin mreq_v <= 1'b1; mreq_w <= 1'b0; mreq_a <= addr; end
                    addr <= addr_nx;
                  end
                end else begin
                  ph <= PH_IDLE;
                end
              end
              PH_AHI: begin
                sda_oe <= 1'b1;
                ahi    <= sh[HI_W-1:0];
                nxt    <= PH_ALO;
              end
              PH_ALO: begin
                sda_oe <= 1'b1;
                addr   <= {ahi, sh};
                nxt    <= PH_WR;
              end
              PH_WR: begin
                sda_oe <= 1'b1;
                nxt    <= PH_WR;
                if (is_ctl) begin
                  cst_v <= 1'b1; cst_a <= addr[7:0]; cst_d <= sh;
                  addr  <= addr_nx;
                end else begin
                  if (!wr_blocked) begin
                    mreq_v <= 1'b1; mreq_w <= 1'b1; mreq_a <= addr; mreq_d <= sh;
                  end
                  addr <= addr_pg;
                end
              end
              PH_RD: begin
                sda_oe <= 1'b0;
                nxt    <= PH_RD;
              end
              default: ph <= PH_IDLE;
            endcase
          end else if (ph == PH_RD) begin
            sda_oe <= ~sh[7];
          end
        end
      end
    end
  end

  assign sda_oe_o    = sda_oe;
  assign mem_valid_o = mreq_v;
  assign mem_write_o = mreq_w;
  assign mem_addr_o  = mreq_a;
  assign mem_wdata_o = mreq_d;

  // R12: a stalled request stays put
  a_r12_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o)
      && $stable(mem_write_o) && $stable(mem_wdata_o)));

  // R9: no write request into the protected region
  a_r9_no_prot_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid_o && mem_write_o) |-> !is_protected(prot, mem_addr_o[ADDR_W-1 -: 2]));

  // R1: release after START or STOP
  a_r1_release_on_cond: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || stop_det) |=> !sda_oe_o);

  // R1: drive changes only with the clock line low, bar the release
  a_r1_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe_o) && !$past(start_det) && !$past(stop_det)) |-> !scl_s);

endmodule

// File: tb/i2cm_target_test.sv
module i2cm_target_test;
  localparam int H = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, mem_valid, mem_ready, mem_write;
  logic [10:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic sda_line;
  assign sda_line = sda_m & ~sda_oe;

  i2cm_target uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .mem_valid_o(mem_valid), .mem_ready_i(mem_ready),
    .mem_write_o(mem_write), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata)
  );

  // memory model with stalls
  logic [7:0] mem [2048];
  logic [2:0] rc = 3'd0;
  logic pv = 1'b0;
  logic [10:0] pa = '0;
  int hold_viol = 0, stalls = 0;
  assign mem_ready = rc[1];
  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    rc <= rc + 3'd1;
    if (pv && !mem_valid) hold_viol++;
    if (pv && mem_addr != pa) hold_viol++;
    pv <= mem_valid && !mem_ready;
    pa <= mem_addr;
    if (mem_valid && !mem_ready) stalls++;
    if (mem_valid && mem_ready && mem_write) mem[mem_addr] <= mem_wdata;
  end

  int errors = 0, checks = 0;
  bit done = 0;

  function automatic logic [7:0] pat(input int a);
    return 8'(a) ^ 8'h5A;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard
  logic [7:0] exp_q[$];
  logic [7:0] act_q[$];
  string      tag_q[$];

  task automatic expect_byte(input logic [7:0] b, input string tag);
    exp_q.push_back(b);
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    logic [7:0] a, e;
    string t;
    if (act_q.size() > 0) begin
      a = act_q.pop_front();
      if (exp_q.size() == 0) begin
        chk("R8 unexpected byte", int'(a), -1);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, int'(a), int'(e));
      end
    end
  end

  // bus driver
  task automatic hw(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hw(H/2);
    scl_m = 1'b1; hw(H/2);
    sda_m = 1'b0; hw(H/2);
    scl_m = 1'b0; hw(H/2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hw(H/2);
    scl_m = 1'b1; hw(H/2);
    sda_m = 1'b1; hw(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      sda_m = b[i]; hw(H/2);
      scl_m = 1'b1; hw(H);
      scl_m = 1'b0; hw(H/2);
    end
  endtask

  task automatic sendc(input logic [7:0] b, input bit exp_ack, input string tag);
    bit ack;
    send_bits(b, 8);
    sda_m = 1'b1; hw(H/2);
    scl_m = 1'b1; hw(H/2);
    ack = (sda_line == 1'b0);
    hw(H/2);
    scl_m = 1'b0; hw(H/2);
    chk(tag, int'(ack), int'(exp_ack));
  endtask

  task automatic recv(input bit mack);
    logic [7:0] b;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hw(H/2); scl_m = 1'b1;
      hw(H/2); b[i] = sda_line;
      hw(H/2); scl_m = 1'b0;
      hw(H/2);
    end
    act_q.push_back(b);
    sda_m = mack ? 1'b0 : 1'b1; hw(H/2);
    scl_m = 1'b1; hw(H);
    scl_m = 1'b0; hw(2);
    sda_m = 1'b1; hw(H/2);
  endtask

  task automatic set_ptr(input logic [3:0] code, input logic [15:0] a, input string tag);
    bus_start();
    sendc({code, 4'b0000}, 1'b1, tag);
    sendc(a[15:8], 1'b1, "R3 address high ack");
    sendc(a[7:0], 1'b1, "R3 address low ack");
  endtask

  task automatic read_run(input logic [3:0] code, input int n);
    bus_start();
    sendc({code, 4'b0001}, 1'b1, "R2 read select ack");
    for (int i = 0; i < n; i++) recv(i < n - 1);
    bus_stop();
    hw(H);
  endtask

  task automatic write_one(input logic [3:0] code, input logic [15:0] a,
                           input logic [7:0] d, input string tag);
    set_ptr(code, a, "R2 write select ack");
    sendc(d, 1'b1, tag);
    bus_stop();
    hw(H);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = pat(i);
    hw(5);
    rst_n = 1'b1;
    hw(5);
    chk("R1 reset data line released", int'(sda_oe), 0);
    chk("R12 reset no request", int'(mem_valid), 0);

    // R5/R6 byte write then current-address read
    write_one(4'b1010, 16'h0005, 8'hA5, "R3 data ack");
    expect_byte(pat(6), "R6 current read after byte write");
    read_run(4'b1010, 1);

    // R7 random read; R4 upper address bits ignored
    set_ptr(4'b1010, 16'hF805, "R4 select ack");
    expect_byte(8'hA5, "R4 upper bits ignored / R7 random read");
    read_run(4'b1010, 1);

    // R5 page write wrapping inside the page
    set_ptr(4'b1010, 16'h007E, "R5 select ack");
    sendc(8'h11, 1'b1, "R5 data ack 0");
    sendc(8'h22, 1'b1, "R5 data ack 1");
    sendc(8'h33, 1'b1, "R5 data ack 2");
    sendc(8'h44, 1'b1, "R5 data ack 3");
    bus_stop(); hw(H);
    expect_byte(pat(8'h42), "R6 pointer after page wrap");
    read_run(4'b1010, 1);
    set_ptr(4'b1010, 16'h007E, "R7 select ack");
    expect_byte(8'h11, "R5 byte at 0x07E");
    expect_byte(8'h22, "R5 byte at 0x07F");
    read_run(4'b1010, 2);
    set_ptr(4'b1010, 16'h0040, "R7 select ack");
    expect_byte(8'h33, "R5 wrapped to 0x040");
    expect_byte(8'h44, "R5 wrapped to 0x041");
    read_run(4'b1010, 2);
    set_ptr(4'b1010, 16'h0080, "R7 select ack");
    expect_byte(pat(8'h80), "R5 next page untouched");
    read_run(4'b1010, 1);

    // R8 sequential read across the array end
    set_ptr(4'b1010, 16'h07FE, "R8 select ack");
    expect_byte(pat(8'hFE), "R8 seq byte 0x7FE");
    expect_byte(pat(8'hFF), "R8 seq byte 0x7FF");
    expect_byte(8'h5A, "R8 seq wrap to 0x000");
    read_run(4'b1010, 3);

    // R2 unknown select code
    bus_start();
    sendc(8'h90, 1'b0, "R2 unknown code no ack");
    sendc(8'h00, 1'b0, "R2 ignored until START");
    bus_stop(); hw(H);
    chk("R1 idle after stop", int'(sda_oe), 0);

    // R10 enable write ended by repeated START is discarded
    set_ptr(4'b1101, 16'h0001, "R10 select ack");
    sendc(8'h02, 1'b1, "R10 enable byte ack");
    set_ptr(4'b1101, 16'h0001, "R10 select ack");
    expect_byte(8'h00, "R10 latch clear after repeated START");
    read_run(4'b1101, 1);
    write_one(4'b1101, 16'h0001, 8'h02, "R10 enable ack");
    set_ptr(4'b1101, 16'h0001, "R10 select ack");
    expect_byte(8'h02, "R10 latch set after STOP");
    read_run(4'b1101, 1);
    write_one(4'b1101, 16'h0000, 8'h01, "R10 protect ack");
    set_ptr(4'b1101, 16'h0000, "R10 select ack");
    expect_byte(8'h01, "R10 protect setting stored");
    read_run(4'b1101, 1);

    // R9 protected upper quarter
    write_one(4'b1010, 16'h0700, 8'hEE, "R9 protected write still acked");
    set_ptr(4'b1010, 16'h0700, "R9 select ack");
    expect_byte(pat(8'h00), "R9 protected byte unchanged");
    read_run(4'b1010, 1);
    write_one(4'b1010, 16'h05FF, 8'h77, "R9 unprotected ack");
    set_ptr(4'b1010, 16'h05FF, "R9 select ack");
    expect_byte(8'h77, "R9 unprotected byte written");
    read_run(4'b1010, 1);

    // R10 protect write refused with the latch clear
    write_one(4'b1101, 16'h0001, 8'h00, "R10 clear ack");
    write_one(4'b1101, 16'h0000, 8'h03, "R10 refused protect ack");
    set_ptr(4'b1101, 16'h0000, "R10 select ack");
    expect_byte(8'h01, "R10 protect unchanged without latch");
    read_run(4'b1101, 1);

    // R11 STOP in the middle of a data byte
    set_ptr(4'b1010, 16'h0010, "R11 select ack");
    send_bits(8'hC3, 4);
    bus_stop(); hw(H);
    chk("R11 released after abort", int'(sda_oe), 0);
    set_ptr(4'b1010, 16'h0010, "R11 select ack");
    expect_byte(pat(8'h10), "R11 aborted byte not written");
    read_run(4'b1010, 1);

    hw(20);
    chk("R8 scoreboard drained", exp_q.size(), 0);
    chk("R12 request held while stalled", hold_viol, 0);
    chk("R12 stalls exercised", int'(stalls > 0), 1);
    finish_run();
  end

endmodule